// File: doc/BRIEF.md
# Configurable Asynchronous Character Transmitter

This block turns one character at a time into a serial frame on a single output line that rests high between frames. A one-cycle start strobe captures a frame-format word (character length of one to eight bits, an optional parity bit with odd or even sense, one or two stop bits, and an optional multiprocessor address bit) together with the data byte and the address flag. The frame is then shifted out one bit per pulse of an externally generated bit-period tick.

A low start bit opens every frame. The data bits follow, least significant first, then the address bit when address mode is on, then the parity bit when parity is on, and finally the high stop bit or bits. The parity covers only the active character bits and, in address mode, the address bit. `busy` is high for the whole frame. `done` pulses for one cycle as the line returns to idle, and a new strobe is accepted from the following cycle.

Top module: `serial_char_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `done` is 0. All format inputs at 0 select one stop bit, no parity, odd parity and a one-bit character.
- R2: A frame sends a 0 start bit, then `char_len+1` data bits taken from `tx_data[0]` upward, then the remaining fields, then stop bits of value 1.
- R3: `fmt_stop2` = 0 ends the frame with one stop bit. `fmt_stop2` = 1 ends it with two.
- R4: With `fmt_par_en` = 0 no parity bit is sent, so the stop bits follow the last data bit or the address bit directly.
- R5: With `fmt_par_en` = 1 a parity bit follows the data (and address) bits. `fmt_par_even` = 0 makes the count of ones over the covered bits plus the parity bit odd. `fmt_par_even` = 1 makes that count even.
- R6: With `fmt_addr_mode` = 1, the value of `tx_addr` is sent as one extra bit right after the last data bit and counts toward the parity.
- R7: Data bits at or above position `char_len+1` are neither sent nor counted in the parity.
- R8: After the strobe the line stays high until the next tick. Each tick then puts the next frame bit on `txd`, registered one cycle later, and the bit holds until the following tick.
- R9: The format, data and address flag are sampled only on the strobe. Changes to them during a frame, and strobes while `busy` is 1, have no effect on the frame in progress, and an ignored strobe does not start a later frame.
- R10: The tick that ends the last stop bit returns `txd` to 1, drops `busy` and raises `done` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_stop2 | input | 1 | 0: one stop bit, 1: two stop bits |
| fmt_par_en | input | 1 | Parity bit present when 1 |
| fmt_par_even | input | 1 | 0: odd parity, 1: even parity |
| char_len | input | 3 | Character length minus one |
| fmt_addr_mode | input | 1 | Address-bit multiprocessor mode |
| tx_data | input | 8 | Character to send |
| tx_addr | input | 1 | Address bit value for address mode |
| start | input | 1 | One-cycle request to send, taken when idle |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench checks character lengths below eight where the data byte has set bits above the length. A design that fails to mask them would send extra bits or flip the parity. It runs address mode with parity in both senses, where leaving the address bit out of the parity inverts the parity bit. It changes every input and fires extra strobes in the middle of frames, which catches a design that reads the format live or restarts on a busy strobe. It also checks the line between ticks and on the closing tick, so an off-by-one in the bit count shows up as a missing or extra stop bit or a late `done`.

// File: rtl/sctx_pkg.sv
package sctx_pkg;

    localparam int unsigned CHAR_W   = 8;
    localparam int unsigned STOP_MAX = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_SEND = 2'd2
    } tx_state_e;

endpackage

// File: rtl/sctx_framer.sv
module sctx_framer #(
    parameter int unsigned DATA_W   = sctx_pkg::CHAR_W,
    parameter int unsigned STOP_MAX = sctx_pkg::STOP_MAX,
    localparam int unsigned LEN_W   = $clog2(DATA_W),
    localparam int unsigned FRAME_W = 1 + DATA_W + 1 + 1 + STOP_MAX,
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               stop2,
    input  logic               par_en,
    input  logic               par_even,
    input  logic [LEN_W-1:0]   len,
    input  logic               addr_mode,
    input  logic [DATA_W-1:0]  data,
    input  logic               addr_bit,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   nbits
);

    logic [DATA_W-1:0] mask_w;
    logic [DATA_W-1:0] live_w;
    logic              fold_w;
    logic              par_bit_w;
    logic [CNT_W-1:0]  pos_w;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            mask_w[i] = (CNT_W'(i) <= CNT_W'(len));
        end
        live_w    = data & mask_w;
        fold_w    = (^live_w) ^ (addr_mode & addr_bit);
        par_bit_w = par_even ? fold_w : ~fold_w;

        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (mask_w[i]) begin
                frame[1 + i] = data[i];
            end
        end
        pos_w = CNT_W'(len) + CNT_W'(2);
        if (addr_mode) begin
            frame[pos_w] = addr_bit;
            pos_w        = pos_w + CNT_W'(1);
        end
        if (par_en) begin
            frame[pos_w] = par_bit_w;
            pos_w        = pos_w + CNT_W'(1);
        end
        nbits = pos_w + CNT_W'(1) + CNT_W'(stop2);
    end

endmodule

// File: rtl/sctx_serializer.sv
module sctx_serializer
    import sctx_pkg::*;
#(
    parameter int unsigned FRAME_W = 13,
    localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               bit_tick,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [CNT_W-1:0]   nbits_in,
    output logic               txd,
    output logic               busy,
    output logic               done
);

    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   left;
        logic               line;
        logic               done;
    } ser_reg_t;

    ser_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.sh   = frame_in;
                    r_d.left = nbits_in;
                    r_d.st   = ST_ARM;
                end
            end
            ST_ARM: begin
                if (bit_tick) begin
                    r_d.line = r_q.sh[0];
                    r_d.sh   = {1'b1, r_q.sh[FRAME_W-1:1]};
                    r_d.left = r_q.left - CNT_W'(1);
                    r_d.st   = ST_SEND;
                end
            end
            ST_SEND: begin
                if (bit_tick) begin
                    if (r_q.left == '0) begin
                        r_d.line = 1'b1;
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.line = r_q.sh[0];
                        r_d.sh   = {1'b1, r_q.sh[FRAME_W-1:1]};
                        r_d.left = r_q.left - CNT_W'(1);
                    end
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.line = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.sh   <= '1;
            r_q.left <= '0;
            r_q.line <= 1'b1;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign txd  = r_q.line;
    assign busy = (r_q.st != ST_IDLE);
    assign done = r_q.done;

    p_idle_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> r_q.line);

    p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ARM && bit_tick) |=> !txd);

    p_len_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && start) |=>
            (r_q.left >= CNT_W'(3) && r_q.left <= CNT_W'(FRAME_W)));

    p_hold_without_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> $stable(txd));

    p_busy_strobe_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SEND && start && !bit_tick) |=> ($stable(r_q.sh) && $stable(r_q.left)));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_closes_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && txd && $past(r_q.st == ST_SEND)));

endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx
    import sctx_pkg::*;
#(
    parameter int unsigned DATA_W   = CHAR_W,
    parameter int unsigned STOP_SEL = STOP_MAX,
    localparam int unsigned LEN_W   = $clog2(DATA_W),
    localparam int unsigned FRAME_W = 1 + DATA_W + 1 + 1 + STOP_SEL,
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_stop2,
    input  logic              fmt_par_en,
    input  logic              fmt_par_even,
    input  logic [LEN_W-1:0]  char_len,
    input  logic              fmt_addr_mode,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_addr,
    input  logic              start,
    input  logic              bit_tick,
    output logic              txd,
    output logic              busy,
    output logic              done
);

    logic [FRAME_W-1:0] frame_w;
    logic [CNT_W-1:0]   nbits_w;

    sctx_framer #(
        .DATA_W   (DATA_W),
        .STOP_MAX (STOP_SEL)
    ) u_framer (
        .stop2     (fmt_stop2),
        .par_en    (fmt_par_en),
        .par_even  (fmt_par_even),
        .len       (char_len),
        .addr_mode (fmt_addr_mode),
        .data      (tx_data),
        .addr_bit  (tx_addr),
        .frame     (frame_w),
        .nbits     (nbits_w)
    );

    sctx_serializer #(
        .FRAME_W (FRAME_W)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .bit_tick (bit_tick),
        .frame_in (frame_w),
        .nbits_in (nbits_w),
        .txd      (txd),
        .busy     (busy),
        .done     (done)
    );

endmodule

// File: tb/sim_serial_char_tx.sv
`timescale 1ns/1ps
module sim_serial_char_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fmt_stop2 = 1'b0, fmt_par_en = 1'b0, fmt_par_even = 1'b0;
    logic [2:0] char_len = 3'd0;
    logic       fmt_addr_mode = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic       tx_addr = 1'b0, start = 1'b0, bit_tick = 1'b0;
    logic       txd, busy, done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    serial_char_tx u0 (
        .clk(clk), .rst_n(rst_n),
        .fmt_stop2(fmt_stop2), .fmt_par_en(fmt_par_en), .fmt_par_even(fmt_par_even),
        .char_len(char_len), .fmt_addr_mode(fmt_addr_mode),
        .tx_data(tx_data), .tx_addr(tx_addr), .start(start), .bit_tick(bit_tick),
        .txd(txd), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic exp_frame(input bit s2, input bit pe, input bit pv, input bit [2:0] ln,
                             input bit am, input bit [7:0] dat, input bit ab,
                             output bit [15:0] fr, output int n);
        int ones;
        fr = '1;
        n = 0;
        ones = 0;
        fr[n] = 1'b0; n = n + 1;
        for (int i = 0; i <= int'(ln); i++) begin
            fr[n] = dat[i];
            ones = ones + int'(dat[i]);
            n = n + 1;
        end
        if (am) begin
            fr[n] = ab; ones = ones + int'(ab); n = n + 1;
        end
        if (pe) begin
            fr[n] = pv ? ones[0] : ~ones[0];
            n = n + 1;
        end
        fr[n] = 1'b1; n = n + 1;
        if (s2) begin
            fr[n] = 1'b1; n = n + 1;
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic run_frame(input bit s2, input bit pe, input bit pv, input bit [2:0] ln,
                             input bit am, input bit [7:0] dat, input bit ab,
                             input bit disturb, input string req);
        bit [15:0] fr;
        int n;
        exp_frame(s2, pe, pv, ln, am, dat, ab, fr, n);
        @(negedge clk);
        fmt_stop2 = s2; fmt_par_en = pe; fmt_par_even = pv; char_len = ln;
        fmt_addr_mode = am; tx_data = dat; tx_addr = ab; start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy == 1'b1, "R9 busy after strobe", int'(busy), 1);
        if (disturb) begin
            fmt_stop2 = ~s2; fmt_par_en = ~pe; fmt_par_even = ~pv; char_len = ~ln;
            fmt_addr_mode = ~am; tx_data = ~dat; tx_addr = ~ab;
        end
        @(negedge clk);
        check(txd == 1'b1, "R8 line high before first tick", int'(txd), 1);
        for (int k = 0; k < n; k++) begin
            pulse_tick();
            check(txd == fr[k], req, int'(txd), int'(fr[k]));
            if (disturb && k == 2) begin
                start = 1'b1;
                @(negedge clk) start = 1'b0;
                check(txd == fr[k], "R9 busy strobe", int'(txd), int'(fr[k]));
            end
            @(negedge clk);
            check(txd == fr[k], "R8 hold between ticks", int'(txd), int'(fr[k]));
        end
        pulse_tick();
        check(done == 1'b1, "R10 done pulse", int'(done), 1);
        check(busy == 1'b0, "R10 busy drop", int'(busy), 0);
        check(txd == 1'b1, "R10 line idle", int'(txd), 1);
        @(negedge clk);
        check(done == 1'b0, "R10 done single cycle", int'(done), 0);
        if (disturb) begin
            pulse_tick();
            check(busy == 1'b0, "R9 ignored strobe no new frame", int'(busy), 0);
            check(txd == 1'b1, "R1 idle line", int'(txd), 1);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R1 reset txd", int'(txd), 1);
        check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        pulse_tick();
        check(txd == 1'b1 && busy == 1'b0, "R1 idle tick", int'(busy), 0);

        // R1: all-zero format, one data bit
        run_frame(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 8'hFF, 1'b0, 1'b0, "R1 zero format frame");
        // R2 R4: eight bits, no parity, one stop
        run_frame(1'b0, 1'b0, 1'b0, 3'd7, 1'b0, 8'hA5, 1'b0, 1'b0, "R2 R4 plain frame");
        // R3 R5: even parity, two stops
        run_frame(1'b1, 1'b1, 1'b1, 3'd7, 1'b0, 8'h37, 1'b0, 1'b0, "R3 R5 even two stop");
        // R5: odd parity
        run_frame(1'b0, 1'b1, 1'b0, 3'd7, 1'b0, 8'h37, 1'b0, 1'b0, "R5 odd parity");
        // R7: five-bit char with set upper bits
        run_frame(1'b0, 1'b1, 1'b1, 3'd4, 1'b0, 8'hE1, 1'b0, 1'b0, "R7 masked upper bits");
        run_frame(1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 8'hF8, 1'b0, 1'b0, "R7 masked odd");
        // R6: address bit folded into parity
        run_frame(1'b0, 1'b1, 1'b1, 3'd7, 1'b1, 8'h01, 1'b1, 1'b0, "R6 addr even parity");
        run_frame(1'b0, 1'b1, 1'b0, 3'd6, 1'b1, 8'h80, 1'b1, 1'b0, "R6 addr odd parity");
        run_frame(1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 8'h0F, 1'b0, 1'b0, "R6 addr no parity");
        // R9: inputs changed and extra strobe mid-frame
        run_frame(1'b0, 1'b1, 1'b0, 3'd7, 1'b1, 8'h5A, 1'b1, 1'b1, "R9 captured format");

        for (int f = 0; f < 40; f++) begin
            bit [31:0] r;
            r = $urandom;
            run_frame(r[0], r[1], r[2], r[5:3], r[6], r[15:8], r[7], r[16], "R2 random frame");
        end

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule